// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Generator

This block drives the gates of one phase leg of a cascaded H-bridge multilevel inverter. A single up/down counter forms a digital triangle. From it the block derives LEVELS-1 carriers, each offset into its own amplitude band, so that together they cover the whole signed reference range. Each clock, the signed reference sample is compared with every carrier. The number of carriers it exceeds is the level index. Each H-bridge cell then turns that index into a four-switch pattern.

Three carrier dispositions can be chosen at run time. In the first, all carriers are in phase. In the second, the carriers above zero are inverted relative to those below. In the third, adjacent carriers alternate. An inverted carrier is the band top minus the shared count, so all carriers stay locked to one counter. A disposition change takes effect only at a carrier valley. Enabling the block is also aligned to a valley. While the block is in reset or disabled, every cell holds the zero-output pattern.

LEVELS must be odd and at least 3. The reference should stay within ±(LEVELS-1)/2·BAND.

Top module: `lspwm_gen`

## Requirements
- R1: There are NC=LEVELS-1 carriers. Carrier j (j=0 at the bottom) equals (j-NC/2)·BAND+t, where t is either the shared count or BAND minus it. `level_o` is the number of carriers strictly below `ref_i`, registered one clock after the inputs it depends on. It lies in 0..NC.
- R2: With `mode_i`=0 (in-phase disposition), every carrier uses t = count.
- R3: With `mode_i`=1 (opposed disposition), carriers j ≥ NC/2 use t = BAND-count, and the others use t = count.
- R4: With `mode_i`=2 (alternating disposition), odd-numbered carriers use t = BAND-count, and even ones use t = count. Code 3 behaves like code 0.
- R5: The shared count is 0 after reset and moves by one every DIV clocks. It rises to BAND and falls back to 0, so one carrier period is 2·BAND·DIV clocks.
- R6: Cell k drives `gate_o[4k+3:4k]` as {lower-right, upper-right, lower-left, upper-left}. The cell gives +Vdc (4'b1001) when `level_o` ≥ NC/2+k+1, gives -Vdc (4'b0110) when `level_o` ≤ NC/2-k-1, and otherwise gives zero with both upper switches closed (4'b0101).
- R7: The two switches of a leg (bits 0/1 and bits 2/3 of a cell) are never on together.
- R8: While `rst_ni` is low, and from the first clock edge at which `en_i` is seen low, every cell shows 4'b0101 and `level_o` equals NC/2.
- R9: After `en_i` rises, the outputs stay as in R8 until a valley step occurs, which is a counter step taken from count 0. Normal outputs appear from the following clock.
- R10: `mode_i` is taken in only at a valley step. Changes at any other time have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Modulation enable |
| mode_i | input | 2 | Disposition: 0 in-phase, 1 opposed about zero, 2 alternating |
| ref_i | input | REF_W | Signed reference sample |
| gate_o | output | 4·(LEVELS-1)/2 | Switch commands, four per cell |
| level_o | output | $clog2(LEVELS) | Registered level index |

## Verification
Every output is one register stage away from its inputs. A change on `ref_i`, `en_i` or the counter therefore appears on `level_o` and `gate_o` at the next rising edge. The bench drives inputs at the falling edge and computes the expected values from its own model of the counter, the latched disposition and the enable state, all taken before that edge. It then waits for one rising edge and compares at the next falling edge. Valley-aligned events (the mode latch and the enable release) follow the same rule and are predicted by the model's own step count.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;
  localparam logic [1:0] MODE_PD   = 2'd0;
  localparam logic [1:0] MODE_POD  = 2'd1;
  localparam logic [1:0] MODE_APOD = 2'd2;

  // {lower-right, upper-right, lower-left, upper-left}
  localparam logic [3:0] SW_POS  = 4'b1001;
  localparam logic [3:0] SW_NEG  = 4'b0110;
  localparam logic [3:0] SW_ZERO = 4'b0101;

  function automatic logic inv_sel(input logic [1:0] mode, input int j, input int nc);
    case (mode)
      MODE_POD:  return (j >= nc / 2);
      MODE_APOD: return ((j % 2) == 1);
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lspwm_carrier.sv
module lspwm_carrier #(
  parameter int BAND = 16,
  parameter int DIV  = 2,
  localparam int CW  = $clog2(BAND + 1),
  localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          valley_o
);
  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          up_q;
  logic          tick;

  assign tick     = (pre_q == PW'(DIV - 1));
  assign valley_o = tick && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick) begin
      pre_q <= '0;
      if (up_q) begin
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(BAND - 1)) up_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) up_q <= 1'b1;
      end
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(BAND)); // R5
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> ((cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q == $past(cnt_q) - CW'(1)))); // R5
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/lspwm_compare.sv
module lspwm_compare #(
  parameter int NC    = 4,
  parameter int BAND  = 16,
  parameter int REF_W = 8,
  localparam int CW   = $clog2(BAND + 1),
  localparam int LW   = $clog2(NC + 1),
  localparam int SW   = REF_W + 2
) (
  input  logic [CW-1:0]           cnt_i,
  input  logic [1:0]              mode_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [NC-1:0]           hit_o,
  output logic [LW-1:0]           level_o
);
  logic signed [SW-1:0] ref_ext;
  assign ref_ext = SW'(ref_i);

  for (genvar j = 0; j < NC; j++) begin : g_car
    localparam int BASE = (j - NC / 2) * BAND;
    logic                 inv;
    logic [CW-1:0]        t;
    logic signed [SW-1:0] car;
    assign inv      = lspwm_pkg::inv_sel(mode_i, j, NC);
    assign t        = inv ? (CW'(BAND) - cnt_i) : cnt_i;
    assign car      = $signed(SW'(BASE)) + $signed(SW'(t));
    assign hit_o[j] = (ref_ext > car);
  end

  always_comb begin
    level_o = '0;
    for (int j = 0; j < NC; j++) level_o = level_o + LW'(hit_o[j]);
  end
endmodule

// File: rtl/lspwm_bridge_map.sv
module lspwm_bridge_map #(
  parameter int NC    = 4,
  localparam int NCELL = NC / 2,
  localparam int LW   = $clog2(NC + 1)
) (
  input  logic [LW-1:0]        level_i,
  output logic [4*NCELL-1:0]   gate_o
);
  import lspwm_pkg::*;

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    logic pos, neg;
    assign pos = (level_i >= LW'(NC / 2 + k + 1));
    assign neg = (level_i <= LW'(NC / 2 - k - 1));
    assign gate_o[4*k +: 4] = pos ? SW_POS : (neg ? SW_NEG : SW_ZERO);
  end
endmodule

// File: rtl/lspwm_gen.sv
module lspwm_gen #(
  parameter int LEVELS = 5,
  parameter int BAND   = 16,
  parameter int DIV    = 2,
  parameter int REF_W  = 8,
  localparam int NC    = LEVELS - 1,
  localparam int NCELL = NC / 2,
  localparam int CW    = $clog2(BAND + 1),
  localparam int LW    = $clog2(NC + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [1:0]              mode_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [4*NCELL-1:0]      gate_o,
  output logic [LW-1:0]           level_o
);
  import lspwm_pkg::*;

  logic [CW-1:0]      cnt;
  logic               valley;
  logic [1:0]         mode_q;
  logic               active_q;
  logic [NC-1:0]      hit;
  logic [LW-1:0]      lvl;
  logic [4*NCELL-1:0] gates;
  logic               run;

  lspwm_carrier #(.BAND(BAND), .DIV(DIV)) i_carrier (
    .clk_i, .rst_ni, .cnt_o(cnt), .valley_o(valley)
  );

  lspwm_compare #(.NC(NC), .BAND(BAND), .REF_W(REF_W)) i_compare (
    .cnt_i(cnt), .mode_i(mode_q), .ref_i, .hit_o(hit), .level_o(lvl)
  );

  lspwm_bridge_map #(.NC(NC)) i_map (.level_i(lvl), .gate_o(gates));

  assign run = en_i && active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_PD;
      active_q <= 1'b0;
      level_o  <= LW'(NC / 2);
      gate_o   <= {NCELL{SW_ZERO}};
    end else begin
      if (valley) mode_q <= mode_i;
      if (!en_i)       active_q <= 1'b0;
      else if (valley) active_q <= 1'b1;
      level_o <= run ? lvl : LW'(NC / 2);
      gate_o  <= run ? gates : {NCELL{SW_ZERO}};
    end
  end

  for (genvar k = 0; k < NCELL; k++) begin : g_leg_chk
    AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gate_o[4*k] && gate_o[4*k+1]) && !(gate_o[4*k+2] && gate_o[4*k+3])); // R7
  end

  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(NC)); // R1
  for (genvar j = 0; j + 1 < NC; j++) begin : g_thermo_chk
    AST_BAND_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[j+1] |-> hit[j]); // R1
  end
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (gate_o == {NCELL{SW_ZERO}}) && (level_o == LW'(NC / 2))); // R8
  AST_START_VALLEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(valley)); // R9
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valley |=> $stable(mode_q)); // R10
endmodule

// File: tb/test_lspwm_gen.sv
`timescale 1ns/1ps
module test_lspwm_gen;
  localparam int LEVELS = 5;
  localparam int BAND   = 16;
  localparam int DIV    = 2;
  localparam int REF_W  = 8;
  localparam int NC     = LEVELS - 1;
  localparam int NCELL  = NC / 2;
  localparam int LW     = $clog2(NC + 1);

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    en_i = 1'b0;
  logic [1:0]              mode_i = 2'd0;
  logic signed [REF_W-1:0] ref_i = '0;
  logic [4*NCELL-1:0]      gate_o;
  logic [LW-1:0]           level_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  int m_pre, m_c, m_mode;
  bit m_up, m_act;

  always #2 clk_i = ~clk_i;

  lspwm_gen #(.LEVELS(LEVELS), .BAND(BAND), .DIV(DIV), .REF_W(REF_W)) i_lspwm_gen (
    .clk_i, .rst_ni, .en_i, .mode_i, .ref_i, .gate_o, .level_o
  );

  function automatic int exp_level(int r, int c, int mode);
    int n = 0;
    for (int j = 0; j < NC; j++) begin
      bit inv;
      int car;
      inv = (mode == 1) ? (j >= NC / 2) : (mode == 2) ? ((j % 2) == 1) : 1'b0;
      car = (j - NC / 2) * BAND + (inv ? BAND - c : c);
      if (r > car) n++;
    end
    return n;
  endfunction

  function automatic int exp_gates(int lv);
    int g = 0;
    for (int k = 0; k < NCELL; k++) begin
      int p;
      if (lv >= NC / 2 + k + 1)      p = 9;  // 4'b1001
      else if (lv <= NC / 2 - k - 1) p = 6;  // 4'b0110
      else                           p = 5;  // 4'b0101
      g = g | (p << (4 * k));
    end
    return g;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(input int el, input string tag);
    int eg;
    bit legs_ok;
    eg = exp_gates(el);
    check(int'(level_o) == el, tag, "level_o", int'(level_o), el);
    check(int'(gate_o) == eg, tag, "gate_o", int'(gate_o), eg);
    legs_ok = 1'b1;
    for (int k = 0; k < NCELL; k++)
      if ((gate_o[4*k] && gate_o[4*k+1]) || (gate_o[4*k+2] && gate_o[4*k+3])) legs_ok = 1'b0;
    check(legs_ok, "R7", "leg overlap", int'(gate_o), eg);
  endtask

  // called at a falling edge; outputs checked at the next falling edge
  task automatic step(input bit en, input int m, input int r, input string tag);
    int el;
    bit tick, valley;
    en_i   = en;
    mode_i = m[1:0];
    ref_i  = r[REF_W-1:0];
    el = (en && m_act) ? exp_level(r, m_c, m_mode) : NC / 2;
    tick   = (m_pre == DIV - 1);
    valley = tick && (m_c == 0);
    if (tick) begin
      m_pre = 0;
      if (m_up) begin m_c++; if (m_c == BAND) m_up = 0; end
      else begin m_c--; if (m_c == 0) m_up = 1; end
    end else m_pre++;
    if (valley) m_mode = m;
    if (!en) m_act = 0;
    else if (valley) m_act = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    check_outputs(el, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_pre = 0; m_c = 0; m_up = 1; m_mode = 0; m_act = 0;
    repeat (3) @(negedge clk_i);
    check_outputs(NC / 2, "R8");  // reset state
    rst_ni = 1'b1;

    // R9: enable waits for a valley
    for (int i = 0; i < 4; i++) step(1, 0, 30, "R9");
    // R5: fixed reference traces the triangle over two periods
    for (int i = 0; i < 4 * BAND * DIV; i++) step(1, 0, 8, "R5");
    // R2: in-phase disposition, varied reference
    for (int i = 0; i < 300; i++) step(1, 0, ((i * 7) % 73) - 36, "R2");
    // R3: opposed disposition
    for (int i = 0; i < 300; i++) step(1, 1, ((i * 11) % 73) - 36, "R3");
    // R4: alternating disposition, then code 3
    for (int i = 0; i < 300; i++) step(1, 2, ((i * 13) % 73) - 36, "R4");
    for (int i = 0; i < 200; i++) step(1, 3, ((i * 5) % 73) - 36, "R4");
    // R1: slow ramp through every band in alternating mode
    for (int i = 0; i < 300; i++) step(1, 2, (i % 73) - 36, "R1");
    // R10: mode toggles every cycle; only valley samples count
    for (int i = 0; i < 300; i++) step(1, i % 3, ((i * 3) % 65) - 32, "R10");
    // R6: extremes and zero
    for (int i = 0; i < 40; i++) step(1, 0, 36, "R6");
    for (int i = 0; i < 40; i++) step(1, 0, -36, "R6");
    for (int i = 0; i < 40; i++) step(1, 1, 0, "R6");
    // R8: disable mid-period
    for (int i = 0; i < 20; i++) step(0, 0, 30, "R8");
    // R9: re-enable at an odd phase
    step(1, 0, 30, "R9");
    for (int i = 0; i < 2 * BAND * DIV + 4; i++) step(1, 0, 30 - i, "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule